// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers eight maskable interrupt lines and one non-maskable line and presents a processor with a single request flag and a vector index. Each maskable line is set at run time as either level-sensitive or edge-sensitive and has its own enable bit. The choice between fixed priority and rotating priority is also made at run time. All lines are active low. Each passes through a two-flop synchroniser before any decision is made on it. A falling edge is the event that an edge-sensitive line and the non-maskable line remember.

The processor takes an interrupt at an instruction boundary by raising the acknowledge input for one cycle. The index shown during that cycle is the source being serviced. Acknowledging the non-maskable source clears its latch. Acknowledging a maskable source in rotating mode moves that source to the lowest priority. Latched edges on maskable lines are cleared by the processor through a per-line clear input.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset no request is presented (intReq low). The rotation pointer gives line 0 the highest priority.
- R2: A falling edge on an edge-sensitive line sets its latch. The latch stays set after the line goes high again, and a rising edge does nothing. The latch clears only on a pulse of that line's clear bit.
- R3: A level-sensitive line is pending only while its synchronised value is low. If it is still low after acknowledge, it is presented again.
- R4: A line whose enable bit is 0 is not presented. An edge arriving on it while disabled is still latched, and it is presented once the line is enabled.
- R5: In fixed mode (rotateMode=0) the lowest-numbered pending enabled line is presented, and vecIdx equals its line number (0 to 7).
- R6: In rotating mode, acknowledging line i makes line i+1 (wrapping 7 to 0) the highest priority and line i the lowest.
- R7: The non-maskable line is edge-latched, outranks every maskable line, ignores the enable bits, is presented with vecIdx = 8, and is cleared by its acknowledge.
- R8: An edge-sensitive line held low for a long time raises exactly one request per falling edge. Once that request is cleared, no new request appears while the line stays low.
- R9: When a clear pulse and a new falling edge on the same line fall in the same cycle, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqLine | input | 8 | Maskable request lines, active low |
| nmiLine | input | 1 | Non-maskable request line, active low |
| edgeSel | input | 8 | Per line: 1 edge-sensitive, 0 level-sensitive |
| maskEn | input | 8 | Per line enable, 1 = may be presented |
| rotateMode | input | 1 | 1 rotating priority, 0 fixed priority |
| edgeClr | input | 8 | Per line clear for latched edges |
| intAck | input | 1 | Acknowledge of the presented source |
| intReq | output | 1 | Some source is pending |
| vecIdx | output | 4 | Index of presented source, 8 for non-maskable |

## Verification
The bench builds the block with its defaults: eight maskable lines, a two-stage synchroniser, and a 4-bit index whose top code 8 belongs to the non-maskable source. With eight lines, a rotating sequence over lines 1, 4 and 6 drives the pointer to 7 and then wraps it. With two synchroniser stages, the cycle in which a new edge meets a clear pulse is known exactly. That lets the bench place the collision on that cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic ackTaken;  // acknowledge accepted while a request is presented
    logic nmiSel;    // the presented source is the non-maskable one
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] fallEdge
);
  logic [WIDTH-1:0] stage [STAGES];
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '1;
      prevQ <= '1;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      prevQ <= stage[STAGES-1];
    end
  end

  assign dout     = stage[STAGES-1];
  assign fallEdge = prevQ & ~dout;
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLine,
  input  logic               nmiLine,
  input  logic [NUM_SRC-1:0] edgeSel,
  input  logic [NUM_SRC-1:0] maskEn,
  input  logic [NUM_SRC-1:0] edgeClr,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] pendVec,
  output logic               nmiPend
);
  localparam int ALL = NUM_SRC + 1;

  logic [ALL-1:0]     syncQ;
  logic [ALL-1:0]     fall;
  logic [NUM_SRC-1:0] edgeLatch;
  logic               nmiLatch;
  logic               nmiClr;

  irq_sync #(.WIDTH(ALL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din({nmiLine, irqLine}),
    .dout(syncQ), .fallEdge(fall)
  );

  assign nmiClr = strobe.ackTaken & strobe.nmiSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeLatch <= '0;
      nmiLatch  <= 1'b0;
    end else begin
      // a new edge wins over a simultaneous clear
      edgeLatch <= (edgeLatch & ~edgeClr) | fall[NUM_SRC-1:0];
      nmiLatch  <= (nmiLatch & ~nmiClr) | fall[NUM_SRC];
    end
  end

  assign pendVec = maskEn & ((edgeSel & edgeLatch) | (~edgeSel & ~syncQ[NUM_SRC-1:0]));
  assign nmiPend = nmiLatch;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
        edgeLatch[i] && !edgeClr[i] |=> edgeLatch[i]);
      p_collide_set_r9: assert property (@(posedge clk) disable iff (!rstN)
        fall[i] |=> edgeLatch[i]);
    end
  endgenerate

  p_nmi_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiLatch) |-> $past(fall[NUM_SRC]));
  p_nmi_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTaken && strobe.nmiSel && !fall[NUM_SRC] |=> !nmiLatch);
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic               nmiPend,
  input  logic               rotateMode,
  input  logic               intAck,
  output logic               intReq,
  output logic [$clog2(NUM_SRC):0] vecIdx,
  output ctrlStrobe_t        strobe
);
  localparam int PTRW = $clog2(NUM_SRC);
  localparam int IDXW = PTRW + 1;
  localparam logic [IDXW-1:0] NMI_IDX = IDXW'(NUM_SRC);
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  logic [PTRW-1:0] ptr;
  logic [PTRW-1:0] selIdx;
  logic            selFound;

  // search from the start point upward, wrapping once around
  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      int c;
      c = rotateMode ? ((int'(ptr) + k) % NUM_SRC) : k;
      if (!selFound && pendVec[c]) begin
        selFound = 1'b1;
        selIdx   = PTRW'(c);
      end
    end
  end

  assign intReq          = nmiPend | selFound;
  assign vecIdx          = nmiPend ? NMI_IDX : {1'b0, selIdx};
  assign strobe.ackTaken = intAck & intReq;
  assign strobe.nmiSel   = nmiPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.ackTaken && !nmiPend && rotateMode) begin
      if (selIdx == PTRW'(NUM_SRC - 1)) ptr <= '0;
      else                              ptr <= selIdx + 1'b1;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> (pendVec == '0) && !nmiPend);
  p_sel_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !nmiPend |-> pendVec[vecIdx[PTRW-1:0]]);
  p_fixed_lowest_r5: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !nmiPend && !rotateMode |->
      ((pendVec & ((ONE << vecIdx[PTRW-1:0]) - ONE)) == '0));
  p_served_demoted_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTaken && !nmiPend && rotateMode && (pendVec != '0) |=>
      rotateMode && (pendVec == $past(pendVec)) && ($countones(pendVec) > 1)
      |-> vecIdx != $past(vecIdx));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLine,
  input  logic               nmiLine,
  input  logic [NUM_SRC-1:0] edgeSel,
  input  logic [NUM_SRC-1:0] maskEn,
  input  logic               rotateMode,
  input  logic [NUM_SRC-1:0] edgeClr,
  input  logic               intAck,
  output logic               intReq,
  output logic [$clog2(NUM_SRC):0] vecIdx
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] pendVec;
  logic               nmiPend;

  irq_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .nmiLine(nmiLine),
    .edgeSel(edgeSel), .maskEn(maskEn), .edgeClr(edgeClr), .strobe(strobe),
    .pendVec(pendVec), .nmiPend(nmiPend)
  );

  irq_control #(.NUM_SRC(NUM_SRC)) u_ctl (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .nmiPend(nmiPend),
    .rotateMode(rotateMode), .intAck(intAck), .intReq(intReq),
    .vecIdx(vecIdx), .strobe(strobe)
  );
endmodule

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqLine = '1;
  logic       nmiLine = 1'b1;
  logic [7:0] edgeSel = '0;
  logic [7:0] maskEn = '1;
  logic       rotateMode = 1'b0;
  logic [7:0] edgeClr = '0;
  logic       intAck = 1'b0;
  logic       intReq;
  logic [3:0] vecIdx;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_ctrl_top uut (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .nmiLine(nmiLine),
    .edgeSel(edgeSel), .maskEn(maskEn), .rotateMode(rotateMode),
    .edgeClr(edgeClr), .intAck(intAck), .intReq(intReq), .vecIdx(vecIdx)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expect a request with the given index, or no request when idx < 0
  task automatic expect_sel(input int idx, input string tag);
    if (idx < 0) chk(intReq == 1'b0, tag, intReq, 0);
    else chk(intReq && vecIdx == idx, tag, intReq ? int'(vecIdx) : -1, idx);
  endtask

  task automatic ack();
    intAck = 1'b1; tick(1); intAck = 1'b0;
  endtask

  task automatic clr(input int line);
    edgeClr[line] = 1'b1; tick(1); edgeClr[line] = 1'b0;
  endtask

  task automatic t_reset();
    expect_sel(-1, "R1 no request after reset");
  endtask

  task automatic t_level();
    irqLine[3] = 1'b0; tick(3);
    expect_sel(3, "R3 level line pending while low");
    ack(); tick(1);
    expect_sel(3, "R3 still low after ack is taken again");
    irqLine[3] = 1'b1; tick(3);
    expect_sel(-1, "R3 level line released");
  endtask

  task automatic t_edge();
    edgeSel[5] = 1'b1;
    irqLine[5] = 1'b0; tick(3);
    expect_sel(5, "R2 falling edge latched");
    irqLine[5] = 1'b1; tick(3);
    expect_sel(5, "R2 latch holds after line returns high");
    clr(5); tick(1);
    expect_sel(-1, "R2 clear pulse empties latch");
    irqLine[5] = 1'b0; tick(3);
    expect_sel(5, "R8 new falling edge latched");
    clr(5); tick(3);
    expect_sel(-1, "R8 no second request while line held low");
    irqLine[5] = 1'b1; tick(3);
    expect_sel(-1, "R2 rising edge ignored");
    irqLine[5] = 1'b0; tick(3);
    expect_sel(5, "R8 next falling edge raises one request");
    clr(5); irqLine[5] = 1'b1; tick(3);
  endtask

  task automatic t_mask();
    edgeSel[2] = 1'b1; maskEn[2] = 1'b0;
    irqLine[2] = 1'b0; tick(1); irqLine[2] = 1'b1; tick(4);
    expect_sel(-1, "R4 disabled line not presented");
    maskEn[2] = 1'b1; tick(1);
    expect_sel(2, "R4 edge kept while disabled appears on enable");
    clr(2); tick(1);
  endtask

  task automatic t_fixed();
    rotateMode = 1'b0;
    irqLine[6] = 1'b0; irqLine[1] = 1'b0; irqLine[4] = 1'b0; tick(3);
    expect_sel(1, "R5 lowest line wins");
    ack(); tick(1);
    expect_sel(1, "R5 fixed order unchanged by ack");
    irqLine[1] = 1'b1; tick(3);
    expect_sel(4, "R5 next lowest line wins");
    irqLine = '1; tick(3);
  endtask

  task automatic t_rotate();
    rotateMode = 1'b1;
    irqLine[6] = 1'b0; irqLine[1] = 1'b0; irqLine[4] = 1'b0; tick(3);
    expect_sel(1, "R6 pointer starts at line 0");
    ack();
    expect_sel(4, "R6 serviced line 1 demoted");
    ack();
    expect_sel(6, "R6 serviced line 4 demoted");
    ack();
    expect_sel(1, "R6 pointer wraps after line 6");
    irqLine = '1; rotateMode = 1'b0; tick(3);
  endtask

  task automatic t_nmi();
    irqLine[0] = 1'b0;
    nmiLine = 1'b0; tick(1); nmiLine = 1'b1; tick(4);
    expect_sel(8, "R7 nmi outranks line 0");
    maskEn = '0; tick(1);
    expect_sel(8, "R7 nmi ignores enables");
    maskEn = '1;
    ack();
    expect_sel(0, "R7 ack clears nmi latch");
    irqLine[0] = 1'b1; tick(3);
    expect_sel(-1, "R7 all quiet after nmi");
  endtask

  task automatic t_collide();
    edgeSel[7] = 1'b1;
    irqLine[7] = 1'b0; tick(3);
    irqLine[7] = 1'b1; tick(3);
    expect_sel(7, "R9 first edge latched");
    irqLine[7] = 1'b0; tick(2);
    edgeClr[7] = 1'b1; tick(1); edgeClr[7] = 1'b0;
    expect_sel(7, "R9 clear meeting new edge leaves latch set");
    clr(7); tick(1);
    expect_sel(-1, "R9 later clear empties latch");
    irqLine[7] = 1'b1; tick(3);
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    t_reset();
    t_level();
    t_edge();
    t_mask();
    t_fixed();
    t_rotate();
    t_nmi();
    t_collide();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule